// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block is the multiply and divide engine that sits beside the execute stage of a 32-bit integer pipeline. A single start command loads two operands and one of four operations: unsigned multiply, signed multiply, unsigned divide or signed divide. The block then runs one bit per clock on one shared shift-and-add/subtract datapath. When it is done it writes the 64-bit product, or the remainder and quotient, into a pair of result registers called HI and LO.

The pipeline reads HI and LO through their output ports. If it requests either result while an operation is still running, the block raises `pause` so the pipeline holds until the result is valid. A new start command issued during an operation drops the old one and begins again with the new operands. Software can also load HI and LO directly, but only while the unit is idle.

Top module: `iterMulDiv`

## Requirements
- R1: After reset, `hiOut` and `loOut` are zero and `pause` is low.
- R2: Command code 2'b00 (bit 1 = divide, bit 0 = signed) multiplies the operands as unsigned numbers: `hiOut` holds the upper 32 bits of the 64-bit product and `loOut` the lower 32 bits.
- R3: Command code 2'b01 multiplies the operands as two's-complement numbers and gives the signed 64-bit product, split across `hiOut`/`loOut` as in R2.
- R4: Command code 2'b10 divides `opA` by `opB` as unsigned numbers: `loOut` holds the quotient and `hiOut` the remainder.
- R5: Command code 2'b11 divides as two's-complement numbers. The quotient is truncated toward zero and the remainder has the sign of the dividend, with the same placement as R4.
- R6: Results appear on `hiOut`/`loOut` from the 32nd rising edge after the edge that accepts the start. In each of the 32 cycles after the start edge, `pause` is high exactly when `hiRead` or `loRead` is high. In every other cycle `pause` is low.
- R7: A start issued while an operation is running abandons that operation. The new command finishes 32 edges after its own start, and only its result appears.
- R8: While the unit is idle, `hiWrite`/`loWrite` load `wrData` into HI/LO, and the new value shows on the output after the next rising edge.
- R9: Direct writes are ignored while an operation is running and in the cycle in which a start is accepted. The finished result is unaffected.
- R10: An unsigned divide by zero finishes normally. It leaves all ones in `loOut` and the dividend in `hiOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| startValid | input | 1 | Start an operation with `cmd`, `opA`, `opB` |
| cmd | input | 2 | Operation: bit 1 divide, bit 0 signed |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| hiWrite | input | 1 | Direct write of HI when idle |
| loWrite | input | 1 | Direct write of LO when idle |
| wrData | input | 32 | Data for direct writes |
| hiRead | input | 1 | Pipeline requests HI this cycle |
| loRead | input | 1 | Pipeline requests LO this cycle |
| hiOut | output | 32 | HI result register |
| loOut | output | 32 | LO result register |
| pause | output | 1 | Stall request: a result was read before it is ready |

## Verification
The hardest state to reach from the ports is an abandoned operation: a second start must land partway through a running operation, and the result must not leak through. The bench starts a long multiply and lets it run a few cycles with no read request, checking that `pause` stays low. It then issues a signed divide and holds a read on HI until `pause` falls, counting the stall cycles from the second start. A separate pass drives writes during the busy window and in the same cycle as a start, then checks that only the operation's result reaches the scoreboard.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  // Command encoding: bit 1 selects divide, bit 0 selects signed arithmetic.
  typedef enum logic [1:0] {
    CMD_MULU = 2'b00,
    CMD_MULS = 2'b01,
    CMD_DIVU = 2'b10,
    CMD_DIVS = 2'b11
  } mduCmd_t;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic load;    // capture operands and mode, prime the accumulator
    logic step;    // perform one iteration
    logic finish;  // this iteration is the last: commit corrected result
    logic wrHi;    // direct load of HI
    logic wrLo;    // direct load of LO
  } mduStrobes_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startValid,
  input  logic             hiWrite,
  input  logic             loWrite,
  input  logic             hiRead,
  input  logic             loRead,
  output mduStrobes_t      strobes,
  output logic             busy,
  output logic [CNT_W-1:0] count,
  output logic             pause
);

  localparam logic [CNT_W-1:0] ITERS = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  // Iteration counter: loaded on start, counts down to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (startValid) begin
      count <= ITERS;
    end else if (count != '0) begin
      count <= count - ONE;
    end
  end

  assign busy = (count != '0);

  always_comb begin
    strobes        = '0;
    strobes.load   = startValid;
    strobes.step   = busy && !startValid;
    strobes.finish = busy && !startValid && (count == ONE);
    strobes.wrHi   = hiWrite && !busy && !startValid;
    strobes.wrLo   = loWrite && !busy && !startValid;
  end

  // Stall the pipeline only if it asks for a result that is not ready.
  assign pause = busy && (hiRead || loRead);

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int DW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  mduStrobes_t      strobes,
  input  logic [1:0]       cmd,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  // Stored mode and sign-fix flags.
  logic divMode;
  logic negMain;   // negate product or quotient
  logic negRem;    // negate remainder

  logic [WIDTH-1:0] opReg;   // multiplicand or divisor magnitude
  logic [DW-1:0]    accReg;  // shifting accumulator
  logic [WIDTH-1:0] hiReg;
  logic [WIDTH-1:0] loReg;

  // Operand magnitudes for the load cycle.
  logic             cmdDiv;
  logic             cmdSigned;
  logic             signA;
  logic             signB;
  logic [WIDTH-1:0] magA;
  logic [WIDTH-1:0] magB;

  always_comb begin
    cmdDiv    = cmd[1];
    cmdSigned = cmd[0];
    signA     = cmdSigned && opA[WIDTH-1];
    signB     = cmdSigned && opB[WIDTH-1];
    magA      = signA ? (~opA + WIDTH'(1)) : opA;
    magB      = signB ? (~opB + WIDTH'(1)) : opB;
  end

  // One multiply iteration: conditional add of the multiplicand into the
  // upper half, then shift the whole accumulator right with the carry.
  logic [WIDTH:0]  mulSum;
  logic [DW-1:0]   mulNext;

  always_comb begin
    mulSum  = {1'b0, accReg[DW-1:WIDTH]} + {1'b0, opReg};
    mulNext = accReg[0] ? {mulSum, accReg[WIDTH-1:1]}
                        : {1'b0, accReg[DW-1:1]};
  end

  // One restoring divide iteration: bring down the next dividend bit,
  // subtract the divisor if it fits, record the quotient bit at the bottom.
  logic [WIDTH:0]  divTop;
  logic [WIDTH:0]  divDiff;
  logic            divFits;
  logic [DW-1:0]   divNext;

  always_comb begin
    divTop  = accReg[DW-1:WIDTH-1];
    divDiff = divTop - {1'b0, opReg};
    divFits = (divTop >= {1'b0, opReg});
    divNext = divFits ? {divDiff[WIDTH-1:0], accReg[WIDTH-2:0], 1'b1}
                      : {accReg[DW-2:0], 1'b0};
  end

  logic [DW-1:0] stepAcc;
  assign stepAcc = divMode ? divNext : mulNext;

  // Sign correction applied to the final accumulator value.
  logic [DW-1:0]    prodFix;
  logic [WIDTH-1:0] quotFix;
  logic [WIDTH-1:0] remFix;
  logic [WIDTH-1:0] resHi;
  logic [WIDTH-1:0] resLo;

  always_comb begin
    prodFix = negMain ? (~stepAcc + DW'(1)) : stepAcc;
    quotFix = negMain ? (~stepAcc[WIDTH-1:0] + WIDTH'(1)) : stepAcc[WIDTH-1:0];
    remFix  = negRem ? (~stepAcc[DW-1:WIDTH] + WIDTH'(1)) : stepAcc[DW-1:WIDTH];
    if (divMode) begin
      resHi = remFix;
      resLo = quotFix;
    end else begin
      resHi = prodFix[DW-1:WIDTH];
      resLo = prodFix[WIDTH-1:0];
    end
  end

  // Operand and accumulator registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      divMode <= 1'b0;
      negMain <= 1'b0;
      negRem  <= 1'b0;
      opReg   <= '0;
      accReg  <= '0;
    end else if (strobes.load) begin
      divMode <= cmdDiv;
      negMain <= signA ^ signB;
      negRem  <= signA;
      opReg   <= cmdDiv ? magB : magA;
      accReg  <= {{WIDTH{1'b0}}, (cmdDiv ? magA : magB)};
    end else if (strobes.step) begin
      accReg  <= stepAcc;
    end
  end

  // Result registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (strobes.finish) begin
      hiReg <= resHi;
      loReg <= resLo;
    end else begin
      if (strobes.wrHi) hiReg <= wrData;
      if (strobes.wrLo) loReg <= wrData;
    end
  end

  assign hiOut = hiReg;
  assign loOut = loReg;

endmodule

// File: rtl/iterMulDiv.sv
module iterMulDiv
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startValid,
  input  logic [1:0]       cmd,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             hiWrite,
  input  logic             loWrite,
  input  logic [WIDTH-1:0] wrData,
  input  logic             hiRead,
  input  logic             loRead,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut,
  output logic             pause
);

  mduStrobes_t      strobes;
  logic             busy;
  logic [CNT_W-1:0] count;

  mdu_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .startValid (startValid),
    .hiWrite    (hiWrite),
    .loWrite    (loWrite),
    .hiRead     (hiRead),
    .loRead     (loRead),
    .strobes    (strobes),
    .busy       (busy),
    .count      (count),
    .pause      (pause)
  );

  mdu_datapath #(.WIDTH(WIDTH)) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .cmd     (cmd),
    .opA     (opA),
    .opB     (opB),
    .wrData  (wrData),
    .hiOut   (hiOut),
    .loOut   (loOut)
  );

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             startValid,
  input logic             hiWrite,
  input logic             loWrite,
  input logic [WIDTH-1:0] wrData,
  input logic             hiRead,
  input logic             loRead,
  input logic [WIDTH-1:0] hiOut,
  input logic [WIDTH-1:0] loOut,
  input logic             pause,
  input logic [CNT_W-1:0] count
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (hiOut == '0) && (loOut == '0) && (count == '0));

  // R6
  pause_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    pause |-> (hiRead || loRead));

  // R6
  pause_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    startValid |=> (pause || !(hiRead || loRead)));

  // R7
  restart_reload_chk: assert property (@(posedge clk) disable iff (rst)
    startValid |=> (count == CNT_W'(WIDTH)));

  // R8
  idle_hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0) && !startValid && hiWrite |=> (hiOut == $past(wrData)));

  // R8
  idle_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0) && !startValid && loWrite |=> (loOut == $past(wrData)));

  // R9
  busy_results_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count > CNT_W'(1)) && !startValid |=> $stable(hiOut) && $stable(loOut));

  // R9
  start_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    startValid |=> $stable(hiOut) && $stable(loOut));

endmodule

bind iterMulDiv mdu_checker #(.WIDTH(WIDTH)) uChk (
  .clk        (clk),
  .rst        (rst),
  .startValid (startValid),
  .hiWrite    (hiWrite),
  .loWrite    (loWrite),
  .wrData     (wrData),
  .hiRead     (hiRead),
  .loRead     (loRead),
  .hiOut      (hiOut),
  .loOut      (loOut),
  .pause      (pause),
  .count      (count)
);

// File: tb/sim_iterMulDiv.sv
module sim_iterMulDiv;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         startValid = 1'b0;
  logic [1:0]   cmd = 2'b00;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         hiWrite = 1'b0;
  logic         loWrite = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         hiRead = 1'b0;
  logic         loRead = 1'b0;
  logic [W-1:0] hiOut;
  logic [W-1:0] loOut;
  logic         pause;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [W-1:0] curHi = '0;
  logic [W-1:0] curLo = '0;

  typedef struct {
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    string        tag;
  } sbItem_t;

  sbItem_t sbQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  iterMulDiv #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .startValid(startValid), .cmd(cmd),
    .opA(opA), .opB(opB), .hiWrite(hiWrite), .loWrite(loWrite),
    .wrData(wrData), .hiRead(hiRead), .loRead(loRead),
    .hiOut(hiOut), .loOut(loOut), .pause(pause)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic logic [63:0] model(input logic [1:0] c,
                                        input logic [W-1:0] a,
                                        input logic [W-1:0] b);
    logic signed [63:0] sa, sb;
    logic signed [W-1:0] qa, qb;
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    qa = a;
    qb = b;
    case (c)
      2'b00: model = {32'b0, a} * {32'b0, b};
      2'b01: model = sa * sb;
      2'b10: model = (b == '0) ? {a, {W{1'b1}}} : {a % b, a / b};
      default: model = {W'(qa % qb), W'(qa / qb)};
    endcase
  endfunction

  // Monitor: pops the scoreboard whenever a read completes without a stall.
  always @(negedge clk) begin
    if (!rst && sbQ.size() > 0 && (hiRead || loRead) && !pause) begin
      sbItem_t it;
      it = sbQ.pop_front();
      check(hiOut == it.hi, {it.tag, " hi"}, {32'b0, hiOut}, {32'b0, it.hi});
      check(loOut == it.lo, {it.tag, " lo"}, {32'b0, loOut}, {32'b0, it.lo});
    end
  end

  task automatic pushExp(input logic [W-1:0] h, input logic [W-1:0] l,
                         input string tag);
    sbItem_t it;
    it.hi = h;
    it.lo = l;
    it.tag = tag;
    sbQ.push_back(it);
    curHi = h;
    curLo = l;
  endtask

  task automatic issue(input logic [1:0] c, input logic [W-1:0] a,
                       input logic [W-1:0] b, input bit withWrite);
    @(posedge clk); #1;
    startValid = 1'b1; cmd = c; opA = a; opB = b;
    hiWrite = withWrite; loWrite = withWrite; wrData = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    startValid = 1'b0; hiWrite = 1'b0; loWrite = 1'b0;
  endtask

  // Hold a read request until the stall drops; return stall cycles.
  task automatic readBack(output int stall);
    hiRead = 1'b1;
    stall = 0;
    @(negedge clk);
    while (pause) begin
      stall++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    hiRead = 1'b0;
  endtask

  task automatic runOp(input logic [1:0] c, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string req);
    logic [63:0] e;
    int stall;
    e = model(c, a, b);
    pushExp(e[63:32], e[31:0], req);
    issue(c, a, b, 1'b0);
    readBack(stall);
    check(stall == W, {req, " R6 stall"}, 64'(stall), 64'(W));
  endtask

  initial begin
    int stall;
    logic [63:0] e;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    hiRead = 1'b1;
    @(negedge clk);
    // R1
    check(hiOut == '0, "R1 hi", {32'b0, hiOut}, 64'd0);
    check(loOut == '0, "R1 lo", {32'b0, loOut}, 64'd0);
    check(pause == 1'b0, "R1 pause", {63'b0, pause}, 64'd0);
    @(posedge clk); #1 hiRead = 1'b0;

    runOp(2'b00, 32'd12345, 32'd6789, "R2 small");
    runOp(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 max");
    runOp(2'b01, 32'hFFFF_FFF9, 32'd13, "R3 neg*pos");
    runOp(2'b01, 32'h8000_0000, 32'h8000_0000, "R3 min*min");
    runOp(2'b01, 32'hFFFF_FF00, 32'hFFFF_FFFD, "R3 neg*neg");
    runOp(2'b10, 32'd1000003, 32'd97, "R4 basic");
    runOp(2'b10, 32'hFFFF_FFFF, 32'd3, "R4 max");
    runOp(2'b10, 32'd5, 32'd9, "R4 small dividend");
    runOp(2'b11, 32'hFFFF_FF85, 32'd7, "R5 neg/pos");
    runOp(2'b11, 32'd123, 32'hFFFF_FFF6, "R5 pos/neg");
    runOp(2'b11, 32'hFFFF_FC00, 32'hFFFF_FFE1, "R5 neg/neg");
    runOp(2'b10, 32'hCAFE_0001, 32'd0, "R10 div by zero");

    // R7: restart mid-operation; only the second command's result appears.
    issue(2'b01, 32'h7654_3210, 32'h0123_4567, 1'b0);
    repeat (4) begin
      @(negedge clk);
      // R6: no read requested, so no stall
      check(pause == 1'b0, "R6 no read", {63'b0, pause}, 64'd0);
    end
    e = model(2'b11, 32'hFFFF_D8F0, 32'd37);
    pushExp(e[63:32], e[31:0], "R7 restart");
    issue(2'b11, 32'hFFFF_D8F0, 32'd37, 1'b0);
    readBack(stall);
    check(stall == W, "R7 stall from second start", 64'(stall), 64'(W));

    // R8: direct writes while idle.
    @(posedge clk); #1 hiWrite = 1'b1; wrData = 32'h1357_9BDF;
    @(posedge clk); #1 hiWrite = 1'b0;
    pushExp(32'h1357_9BDF, curLo, "R8 hi write");
    readBack(stall);
    @(posedge clk); #1 loWrite = 1'b1; wrData = 32'h2468_ACE0;
    @(posedge clk); #1 loWrite = 1'b0;
    pushExp(curHi, 32'h2468_ACE0, "R8 lo write");
    readBack(stall);

    // R9: writes during busy window are ignored.
    e = model(2'b00, 32'd77777, 32'd88888);
    pushExp(e[63:32], e[31:0], "R9 busy write");
    issue(2'b00, 32'd77777, 32'd88888, 1'b0);
    hiWrite = 1'b1; loWrite = 1'b1; wrData = 32'hA5A5_A5A5;
    repeat (10) @(posedge clk);
    #1 hiWrite = 1'b0; loWrite = 1'b0;
    readBack(stall);

    // R9: write in the same cycle as the start is ignored.
    e = model(2'b10, 32'd999, 32'd10);
    pushExp(e[63:32], e[31:0], "R9 write with start");
    issue(2'b10, 32'd999, 32'd10, 1'b1);
    readBack(stall);
    check(stall == W, "R9 stall", 64'(stall), 64'(W));

    check(sbQ.size() == 0, "scoreboard drained", 64'(sbQ.size()), 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule